// File: doc/BRIEF.md
# Matrix Keypad Scanner and Encoder

This block reads a 4×4 matrix of momentary switches. It pulls one column low at a time. Each row has a pull-up and is read back as an input. A row that reads low while its column is driven marks a closed switch at that crossing. The row inputs pass through a two-stage synchronizer before the scan logic sees them.

A single divided tick from the system clock sets the pace for everything. It steps the active column, and it also counts the debounce interval, both for a new press and for a release. When a closed switch is first seen, the scan stops on that column. The candidate must stay closed over a run of consecutive ticks before it is accepted. The scan also stays on that column while the accepted key is held. The block then presents a 4-bit key code with a data-available flag, and pulses a one-cycle strobe for each newly accepted key. A second key pressed during a hold does not disturb the reported code. Once the first key is released, the second key is picked up as a fresh key (two-key rollover).

The tick divider and the debounce length are parameters. A 20 ms interval in silicon can therefore shrink to a few dozen cycles in simulation.

Top module: `keypad_scanner`

## Requirements
- R1: Exactly one bit of `colDrvN` is low at every cycle; bit c low means column c is active; after reset column 0 is active, and with no key pressed the active column steps 0→1→2→3→0 once every TICK_DIV cycles.
- R2: A row input reading 0 while column c is driven means the key at (row r, column c) is closed, and it is reported as `keyCode` = c×4 + r (4 bits, rows 0..3, columns 0..3).
- R3: A key is accepted only after it has been seen closed on DEBOUNCE_TICKS+1 consecutive scan ticks; a press lasting fewer ticks produces no strobe and leaves `keyValid` low.
- R4: `keyStrobe` is high for exactly one cycle per accepted key, in the same cycle as the new `keyCode` and with `keyValid` high.
- R5: `keyValid` stays high while the accepted key is held; a release shorter than DEBOUNCE_TICKS ticks neither clears it nor causes a new strobe; it clears after the key has read open on DEBOUNCE_TICKS consecutive ticks.
- R6: While a candidate is being debounced and while an accepted key is held, the active column stays on that key's column.
- R7: A second key pressed while the first is held changes neither `keyCode` nor the strobe count; after the first key is released, the second is accepted with its own code and one new strobe.
- R8: When several keys in the same column close together, the lowest row index is reported.
- R9: During reset `keyValid` and `keyStrobe` are 0 and `keyCode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| rowIn | input | 4 | Row sense lines, externally pulled high, low = closed switch on active column |
| colDrvN | output | 4 | Column drives, the one low bit is the active column |
| keyCode | output | 4 | Code of the accepted key, column×4 + row |
| keyValid | output | 1 | High while an accepted key is held |
| keyStrobe | output | 1 | One-cycle pulse when a new key code is latched |

## Verification
The assertions assume the row inputs depend only on which column is driven and on the set of closed switches. They also assume TICK_DIV is at least 4, so the synchronized rows have settled before the next tick looks at them. The bench models the matrix as a combinational function of `colDrvN` and a vector of pressed keys, so this assumption holds by construction. Presses and releases are either held far longer than a full scan plus debounce, or cut deliberately shorter than the debounce window. This keeps every expected outcome free of dependence on the scan phase.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic advCol;     // step to the next column
    logic loadCand;   // capture the lowest closed row as candidate
    logic clrCnt;     // zero the debounce counter
    logic incCnt;     // count one more tick
    logic latchCode;  // accept candidate: latch code, pulse strobe
  } kpCtrl_t;

  typedef enum logic [1:0] {
    ST_SCAN  = 2'd0,
    ST_CHECK = 2'd1,
    ST_HELD  = 2'd2
  } kpState_t;

endpackage

// File: rtl/kp_datapath.sv
module kp_datapath
  import keypad_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int TICK_DIV = 4,
  parameter int DEBOUNCE_TICKS = 5,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS),
  localparam int CODE_W = $clog2(ROWS * COLS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ROWS-1:0]   rowIn,
  input  kpCtrl_t           ctrl,
  output logic              tick,
  output logic              anyLow,
  output logic              candLow,
  output logic              cntDone,
  output logic [COLS-1:0]   colDrvN,
  output logic [CODE_W-1:0] keyCode,
  output logic              keyStrobe
);

  localparam int TCK_W = $clog2(TICK_DIV);
  localparam int CNT_W = $clog2(DEBOUNCE_TICKS + 1);

  logic [TCK_W-1:0] tickCnt;
  logic [ROWS-1:0]  rowSync1, rowSync2;
  logic [COL_W-1:0] colIdx;
  logic [ROW_W-1:0] candRow, firstLow;
  logic [CNT_W-1:0] debCnt;

  // Shared time base: one tick every TICK_DIV cycles.
  always_ff @(posedge clk) begin
    if (!rstN) tickCnt <= '0;
    else if (tick) tickCnt <= '0;
    else tickCnt <= tickCnt + 1'b1;
  end
  assign tick = (tickCnt == TCK_W'(TICK_DIV - 1));

  // Two-stage row synchronizer, idle value is all ones (pulled up).
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowSync1 <= '1;
      rowSync2 <= '1;
    end else begin
      rowSync1 <= rowIn;
      rowSync2 <= rowSync1;
    end
  end

  assign anyLow = ~&rowSync2;

  // Lowest closed row wins.
  always_comb begin
    firstLow = '0;
    for (int r = ROWS - 1; r >= 0; r--)
      if (!rowSync2[r]) firstLow = ROW_W'(r);
  end

  // Column pointer and one-hot-low column drive.
  always_ff @(posedge clk) begin
    if (!rstN) colIdx <= '0;
    else if (ctrl.advCol) begin
      if (colIdx == COL_W'(COLS - 1)) colIdx <= '0;
      else colIdx <= colIdx + 1'b1;
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_colDrv
    assign colDrvN[c] = (colIdx != COL_W'(c));
  end

  // Candidate row and debounce counter.
  always_ff @(posedge clk) begin
    if (!rstN) candRow <= '0;
    else if (ctrl.loadCand) candRow <= firstLow;
  end
  assign candLow = ~rowSync2[candRow];

  always_ff @(posedge clk) begin
    if (!rstN) debCnt <= '0;
    else if (ctrl.clrCnt) debCnt <= '0;
    else if (ctrl.incCnt) debCnt <= debCnt + 1'b1;
  end
  assign cntDone = (debCnt == CNT_W'(DEBOUNCE_TICKS - 1));

  // Code register and acceptance strobe.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyCode   <= '0;
      keyStrobe <= 1'b0;
    end else begin
      keyStrobe <= ctrl.latchCode;
      if (ctrl.latchCode)
        keyCode <= CODE_W'(colIdx) * CODE_W'(ROWS) + CODE_W'(candRow);
    end
  end

  // R1: only one column is ever driven
  a_r1_one_column: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~colDrvN) == 1);

  // R3: the debounce counter never runs past its limit
  a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rstN)
    debCnt < CNT_W'(DEBOUNCE_TICKS));

endmodule

// File: rtl/kp_control.sv
module kp_control
  import keypad_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    anyLow,
  input  logic    candLow,
  input  logic    cntDone,
  output kpCtrl_t ctrl,
  output logic    keyValid
);

  kpState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_SCAN;
    else state <= nextState;
  end

  always_comb begin
    ctrl      = '0;
    nextState = state;
    if (tick) begin
      case (state)
        ST_SCAN: begin
          if (anyLow) begin
            ctrl.loadCand = 1'b1;
            ctrl.clrCnt   = 1'b1;
            nextState     = ST_CHECK;
          end else begin
            ctrl.advCol = 1'b1;
          end
        end
        ST_CHECK: begin
          if (!candLow) begin
            ctrl.advCol = 1'b1;
            nextState   = ST_SCAN;
          end else if (cntDone) begin
            ctrl.latchCode = 1'b1;
            ctrl.clrCnt    = 1'b1;
            nextState      = ST_HELD;
          end else begin
            ctrl.incCnt = 1'b1;
          end
        end
        ST_HELD: begin
          if (candLow) begin
            ctrl.clrCnt = 1'b1;
          end else if (cntDone) begin
            ctrl.advCol = 1'b1;
            nextState   = ST_SCAN;
          end else begin
            ctrl.incCnt = 1'b1;
          end
        end
        default: nextState = ST_SCAN;
      endcase
    end
  end

  assign keyValid = (state == ST_HELD);

  // R6: no column step while a candidate is under test and still closed
  a_r6_hold_column: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && candLow) |-> !ctrl.advCol);

  // R3: acceptance only follows a debounce check
  a_r3_accept_path: assert property (@(posedge clk) disable iff (!rstN)
    $rose(keyValid) |-> $past(state) == ST_CHECK);

endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import keypad_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int TICK_DIV = 4,
  parameter int DEBOUNCE_TICKS = 5,
  localparam int CODE_W = $clog2(ROWS * COLS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ROWS-1:0]   rowIn,
  output logic [COLS-1:0]   colDrvN,
  output logic [CODE_W-1:0] keyCode,
  output logic              keyValid,
  output logic              keyStrobe
);

  kpCtrl_t ctrl;
  logic    tick, anyLow, candLow, cntDone;

  kp_datapath #(
    .ROWS(ROWS), .COLS(COLS), .TICK_DIV(TICK_DIV), .DEBOUNCE_TICKS(DEBOUNCE_TICKS)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .rowIn(rowIn), .ctrl(ctrl),
    .tick(tick), .anyLow(anyLow), .candLow(candLow), .cntDone(cntDone),
    .colDrvN(colDrvN), .keyCode(keyCode), .keyStrobe(keyStrobe)
  );

  kp_control i_control (
    .clk(clk), .rstN(rstN), .tick(tick), .anyLow(anyLow),
    .candLow(candLow), .cntDone(cntDone), .ctrl(ctrl), .keyValid(keyValid)
  );

  // R4: strobe lasts one cycle
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rstN)
    keyStrobe |=> !keyStrobe);

  // R4: strobe only with the flag raised
  a_r4_strobe_valid: assert property (@(posedge clk) disable iff (!rstN)
    keyStrobe |-> keyValid);

  // R7: the code holds steady through a hold
  a_r7_code_stable: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && $past(keyValid)) |-> $stable(keyCode));

  // R6: the column is frozen through a hold
  a_r6_col_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && $past(keyValid)) |-> $stable(colDrvN));

endmodule

// File: tb/test_keypad_scanner.sv
module test_keypad_scanner;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int TICK_DIV = 4;
  localparam int DEB = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] pressed = '0;
  logic [3:0]  rowIn, colDrvN, keyCode;
  logic        keyValid, keyStrobe;
  int          checks = 0, errors = 0, strobeCnt = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  keypad_scanner #(.ROWS(ROWS), .COLS(COLS), .TICK_DIV(TICK_DIV), .DEBOUNCE_TICKS(DEB))
    i_keypad_scanner (.clk(clk), .rstN(rstN), .rowIn(rowIn), .colDrvN(colDrvN),
                      .keyCode(keyCode), .keyValid(keyValid), .keyStrobe(keyStrobe));

  // Switch matrix model: a row reads low when a closed key sits on a driven column.
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      rowIn[r] = 1'b1;
      for (int c = 0; c < COLS; c++)
        if (pressed[c*ROWS + r] && !colDrvN[c]) rowIn[r] = 1'b0;
    end
  end

  always @(posedge clk) if (rstN && keyStrobe) strobeCnt++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    logic [3:0] cur;
    cyc(3);
    // R9: reset state
    chk(keyValid == 1'b0, "R9 keyValid in reset", keyValid, 0);
    chk(keyStrobe == 1'b0, "R9 keyStrobe in reset", keyStrobe, 0);
    chk(keyCode == 4'd0, "R9 keyCode in reset", keyCode, 0);
    chk(colDrvN == 4'b1110, "R1 column 0 in reset", colDrvN, 4'b1110);
    rstN = 1'b1;

    // R1: idle column rotation period
    for (int i = 0; i < 6; i++) begin
      cur = colDrvN;
      while (colDrvN == cur) cyc(1);
      cur = colDrvN;
      chk($countones(~cur) == 1, "R1 one column low", cur, 0);
      cyc(TICK_DIV - 1);
      chk(colDrvN == cur, "R1 column held for a tick period", colDrvN, cur);
      cyc(1);
      chk(colDrvN == {cur[2:0], cur[3]}, "R1 column steps to next", colDrvN, {cur[2:0], cur[3]});
    end

    // R2, R4, R5, R6: every key of the matrix
    for (int k = 0; k < 16; k++) begin
      base = strobeCnt;
      pressed[k] = 1'b1;
      cyc(80);
      chk(keyValid == 1'b1, "R2 keyValid after press", keyValid, 1);
      chk(keyCode == 4'(k), "R2 code = col*4+row", keyCode, k);
      chk(strobeCnt == base + 1, "R4 one strobe per key", strobeCnt - base, 1);
      chk(colDrvN[k/4] == 1'b0, "R6 column parked on held key", colDrvN, k/4);
      pressed[k] = 1'b0;
      cyc(60);
      chk(keyValid == 1'b0, "R5 valid clears after release", keyValid, 0);
    end

    // R3: a too-short press is rejected
    base = strobeCnt;
    pressed[9] = 1'b1;
    cyc(12);
    pressed[9] = 1'b0;
    cyc(60);
    chk(strobeCnt == base, "R3 short press no strobe", strobeCnt - base, 0);
    chk(keyValid == 1'b0, "R3 short press no valid", keyValid, 0);

    // R5: a brief release does not end the hold
    pressed[6] = 1'b1;
    cyc(80);
    base = strobeCnt;
    pressed[6] = 1'b0;
    cyc(8);
    pressed[6] = 1'b1;
    cyc(60);
    chk(keyValid == 1'b1, "R5 glitch keeps valid", keyValid, 1);
    chk(strobeCnt == base, "R5 glitch no new strobe", strobeCnt - base, 0);
    chk(keyCode == 4'd6, "R5 glitch keeps code", keyCode, 6);
    pressed[6] = 1'b0;
    cyc(60);
    chk(keyValid == 1'b0, "R5 full release clears", keyValid, 0);

    // R7: two-key rollover
    pressed[1] = 1'b1;
    cyc(80);
    base = strobeCnt;
    chk(keyCode == 4'd1, "R7 first key code", keyCode, 1);
    pressed[14] = 1'b1;
    cyc(100);
    chk(keyCode == 4'd1, "R7 second key does not replace code", keyCode, 1);
    chk(strobeCnt == base, "R7 second key no strobe while first held", strobeCnt - base, 0);
    chk(keyValid == 1'b1, "R7 valid through rollover", keyValid, 1);
    pressed[1] = 1'b0;
    cyc(120);
    chk(keyCode == 4'd14, "R7 second key accepted after release", keyCode, 14);
    chk(strobeCnt == base + 1, "R7 one strobe for second key", strobeCnt - base, 1);
    chk(keyValid == 1'b1, "R7 valid for second key", keyValid, 1);
    pressed[14] = 1'b0;
    cyc(60);
    chk(keyValid == 1'b0, "R7 valid clears at end", keyValid, 0);

    // R8: two rows in one column, lowest row wins
    pressed[5] = 1'b1;
    pressed[6] = 1'b1;
    cyc(80);
    chk(keyCode == 4'd5, "R8 lowest row priority", keyCode, 5);
    pressed[5] = 1'b0;
    pressed[6] = 1'b0;
    cyc(60);
    chk(keyValid == 1'b0, "R8 release clears", keyValid, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule